// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is a synthesizable model of a single-port, flow-through synchronous burst memory with 18-bit words split into two 9-bit lanes. On every rising clock edge it samples the address, three chip enables, two address strobes, a burst-advance input, the write controls and the write data. From these it picks one of four cycle types: deselect, start a burst at the external address, step to the next burst address, or hold the current address as a wait cycle. A write stores only the lanes that the write controls select.

Read data is combinational from the array at the registered address, so it appears in the cycle right after the edge that loaded that address. The output is presented as a data bus plus a drive-enable, in the manner of a tri-state pad. The drive-enable follows an asynchronous active-low output enable and an asynchronous sleep input. Sleep also forces deselect at the edge and blocks writes, but it leaves the stored words intact.

Top module: `sram_burst_ctrl`

## Requirements
- R1: After reset, and until a selected read cycle has been started, `data_oe_o` is low.
- R2: The device is selected only when `ce_ni`=0, `ce2_ni`=0 and `ce3_i`=1. A strobe with any enable inactive gives a deselect cycle with `data_oe_o` low. While deselected, strobe-free cycles stay deselected whatever `adv_ni` does.
- R3: `adsp_ni`=0 together with `ce_ni`=0 starts a read at `addr_i` and writes nothing, whatever the write controls are. It takes priority over `adsc_ni`. With `ce_ni`=1, `adsp_ni` is ignored.
- R4: `adsc_ni`=0, when R3 does not apply and the device is selected, starts a burst at `addr_i`. The cycle is a write if the write controls request one (R8) and a read otherwise.
- R5: With both strobes high in an active burst, `adv_ni`=0 steps a 2-bit burst counter. The two low address bits follow R7 and the upper bits stay at the start address.
- R6: With both strobes high in an active burst, `adv_ni`=1 keeps the current address as a wait cycle.
- R7: `lin_mode_i`=1 gives low bits equal to (start + k) mod 4. `lin_mode_i`=0 gives low bits equal to start XOR k, where k is the burst count.
- R8: A write is requested when `gw_ni`=0, or when `bwe_ni`=0 with at least one bit of `lane_we_ni` low. `gw_ni`=0 writes all 18 bits. Otherwise `lane_we_ni[0]`=0 writes bits 8:0 and `lane_we_ni[1]`=0 writes bits 17:9. `gw_ni`=1 with `bwe_ni`=1 is a read.
- R9: A continue or wait cycle that requests a write stores the data at that cycle's burst address. This includes the wait cycle that follows a read started by `adsp_ni`.
- R10: `data_oe_o` is high only in an active, non-write cycle with `oe_ni`=0. `data_o` is zero whenever `data_oe_o` is low.
- R11: `sleep_i`=1 forces `data_oe_o` low at once, deselects at the edge and blocks writes. The array keeps its contents.
- R12: While `data_oe_o` is high, `data_o` equals the array word at the address registered by the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External word address |
| ce_ni | input | 1 | Primary chip enable, active low; also gates `adsp_ni` |
| ce2_ni | input | 1 | Second chip enable, active low |
| ce3_i | input | 1 | Third chip enable, active high |
| adsp_ni | input | 1 | Read-only address strobe, active low |
| adsc_ni | input | 1 | Read/write address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write of all lanes, active low |
| bwe_ni | input | 1 | Lane-write gate, active low |
| lane_we_ni | input | LANES | Per-lane write enables, active low; bit 0 is bits 8:0 |
| lin_mode_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| sleep_i | input | 1 | Sleep, active high, asynchronous |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| data_i | input | LANES*LANE_W | Write data |
| data_o | output | LANES*LANE_W | Read data, zero when not driven |
| data_oe_o | output | 1 | Drive enable for `data_o` |

## Verification
The assertions assume that every input holds a known value at each rising edge. They also assume that the asynchronous inputs `oe_ni` and `sleep_i` change only between edges, so that the drive-enable seen at an edge is consistent with those inputs at that edge. The bench changes all inputs two nanoseconds after an edge and samples the outputs just before changing them. It first writes every word with a known pattern, so reads never return uninitialised data. It then mixes directed bursts with random strobes, enables and write controls, weighted so that bursts actually run for several cycles.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_START = 2'd1,
    OP_NEXT  = 2'd2,
    OP_HOLD  = 2'd3
  } burst_op_e;
endpackage

// File: rtl/sbs_cycle_dec.sv
module sbs_cycle_dec
  import sram_burst_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             ce_ni,
  input  logic             ce2_ni,
  input  logic             ce3_i,
  input  logic             adsp_ni,
  input  logic             adsc_ni,
  input  logic             adv_ni,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] lane_we_ni,
  input  logic             sleep_i,
  input  logic             active_q_i,
  output burst_op_e        op_o,
  output logic             active_d_o,
  output logic             wr_o,
  output logic [LANES-1:0] lane_mask_o
);
  logic sel_ok, wr_req;

  assign sel_ok = ~ce_ni & ~ce2_ni & ce3_i;
  assign wr_req = ~gw_ni | (~bwe_ni & ~(&lane_we_ni));

  always_comb begin
    op_o       = OP_IDLE;
    active_d_o = 1'b0;
    wr_o       = 1'b0;
    if (sleep_i) begin
      op_o = OP_IDLE;
    end else if (~adsp_ni & ~ce_ni) begin
      // processor strobe: always a read
      if (sel_ok) begin
        op_o       = OP_START;
        active_d_o = 1'b1;
      end
    end else if (~adsc_ni) begin
      if (sel_ok) begin
        op_o       = OP_START;
        active_d_o = 1'b1;
        wr_o       = wr_req;
      end
    end else if (active_q_i) begin
      op_o       = adv_ni ? OP_HOLD : OP_NEXT;
      active_d_o = 1'b1;
      wr_o       = wr_req;
    end
  end

  always_comb begin
    if (!wr_o)       lane_mask_o = '0;
    else if (!gw_ni) lane_mask_o = '1;
    else             lane_mask_o = ~lane_we_ni;
  end
endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  burst_op_e         op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lin_mode_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] nxt_addr_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q, cnt_inc;

  function automatic logic [ADDR_W-1:0] form_addr(
      input logic [ADDR_W-1:0] base, input logic [BURST_W-1:0] k, input logic lin);
    logic [BURST_W-1:0] lo;
    lo = lin ? (base[BURST_W-1:0] + k) : (base[BURST_W-1:0] ^ k);
    return {base[ADDR_W-1:BURST_W], lo};
  endfunction

  assign cnt_inc    = cnt_q + 1'b1;
  assign cur_addr_o = form_addr(base_q, cnt_q, lin_mode_i);

  always_comb begin
    unique case (op_i)
      OP_START: nxt_addr_o = addr_i;
      OP_NEXT:  nxt_addr_o = form_addr(base_q, cnt_inc, lin_mode_i);
      default:  nxt_addr_o = cur_addr_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (op_i)
        OP_START: begin
          base_q <= addr_i;
          cnt_q  <= '0;
        end
        OP_NEXT: cnt_q <= cnt_inc;
        default: ;
      endcase
    end
  end

  if (HI_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed BURST_W");
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [LANES-1:0]        wr_mask_i,
  input  logic [LANES*LANE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [LANES*LANE_W-1:0] rd_data_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_mask_i[l]) mem[wr_addr_i][l*LANE_W +: LANE_W] <= wr_data_i[l*LANE_W +: LANE_W];
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 2,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    ce_ni,
  input  logic                    ce2_ni,
  input  logic                    ce3_i,
  input  logic                    adsp_ni,
  input  logic                    adsc_ni,
  input  logic                    adv_ni,
  input  logic                    gw_ni,
  input  logic                    bwe_ni,
  input  logic [LANES-1:0]        lane_we_ni,
  input  logic                    lin_mode_i,
  input  logic                    sleep_i,
  input  logic                    oe_ni,
  input  logic [LANES*LANE_W-1:0] data_i,
  output logic [LANES*LANE_W-1:0] data_o,
  output logic                    data_oe_o
);
  localparam int WORD_W = LANES * LANE_W;

  burst_op_e         op;
  logic              active_q, active_d, wr_q, wr;
  logic [LANES-1:0]  lane_mask;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  logic [WORD_W-1:0] rd_data;

  sbs_cycle_dec #(.LANES(LANES)) u_dec (
    .ce_ni      (ce_ni),
    .ce2_ni     (ce2_ni),
    .ce3_i      (ce3_i),
    .adsp_ni    (adsp_ni),
    .adsc_ni    (adsc_ni),
    .adv_ni     (adv_ni),
    .gw_ni      (gw_ni),
    .bwe_ni     (bwe_ni),
    .lane_we_ni (lane_we_ni),
    .sleep_i    (sleep_i),
    .active_q_i (active_q),
    .op_o       (op),
    .active_d_o (active_d),
    .wr_o       (wr),
    .lane_mask_o(lane_mask)
  );

  sbs_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .addr_i    (addr_i),
    .lin_mode_i(lin_mode_i),
    .cur_addr_o(cur_addr),
    .nxt_addr_o(nxt_addr)
  );

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i    (clk_i),
    .wr_addr_i(nxt_addr),
    .wr_mask_i(lane_mask),
    .wr_data_i(data_i),
    .rd_addr_i(cur_addr),
    .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      active_q <= active_d;
      wr_q     <= wr;
    end
  end

  // output drive: read cycle, enabled, awake
  assign data_oe_o = active_q & ~wr_q & ~oe_ni & ~sleep_i;
  assign data_o    = data_oe_o ? rd_data : '0;
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    ce_ni,
  input logic                    ce2_ni,
  input logic                    ce3_i,
  input logic                    adsp_ni,
  input logic                    adsc_ni,
  input logic                    gw_ni,
  input logic                    bwe_ni,
  input logic [LANES-1:0]        lane_we_ni,
  input logic                    sleep_i,
  input logic                    oe_ni,
  input logic [LANES*LANE_W-1:0] data_o,
  input logic                    data_oe_o
);
  logic sel_ok, wr_req, p_start;
  assign sel_ok  = ~ce_ni & ~ce2_ni & ce3_i;
  assign wr_req  = ~gw_ni | (~bwe_ni & ~(&lane_we_ni));
  assign p_start = ~adsp_ni & ~ce_ni;

  assert_sleep_blanks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !data_oe_o);

  assert_oe_gates_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !data_oe_o);

  assert_undriven_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));

  assert_deselect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsc_ni && !sel_ok) |=> !data_oe_o);

  assert_adsp_reads_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_start && sel_ok && !sleep_i) |=> (oe_ni || sleep_i || data_oe_o));

  assert_write_hiz_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsc_ni && !p_start && sel_ok && wr_req && !sleep_i) |=> !data_oe_o);
endmodule

bind sram_burst_ctrl sbs_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_sbs_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_ni     (ce_ni),
  .ce2_ni    (ce2_ni),
  .ce3_i     (ce3_i),
  .adsp_ni   (adsp_ni),
  .adsc_ni   (adsc_ni),
  .gw_ni     (gw_ni),
  .bwe_ni    (bwe_ni),
  .lane_we_ni(lane_we_ni),
  .sleep_i   (sleep_i),
  .oe_ni     (oe_ni),
  .data_o    (data_o),
  .data_oe_o (data_oe_o)
);

// File: tb/tb_sram_burst_ctrl.sv
`timescale 1ns/1ps
module tb_sram_burst_ctrl;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic ce_n, ce2_n, ce3, adsp_n, adsc_n, adv_n, gw_n, bwe_n, lin, sleep, oe_n;
  logic [1:0] lane_n;
  logic [17:0] din, dout;
  logic doe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sram_burst_ctrl #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ce_ni(ce_n), .ce2_ni(ce2_n),
    .ce3_i(ce3), .adsp_ni(adsp_n), .adsc_ni(adsc_n), .adv_ni(adv_n), .gw_ni(gw_n),
    .bwe_ni(bwe_n), .lane_we_ni(lane_n), .lin_mode_i(lin), .sleep_i(sleep),
    .oe_ni(oe_n), .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  // reference state
  logic [17:0] rmem [DEPTH];
  logic        ract = 1'b0, rwr = 1'b0;
  logic [AW-1:0] rbase = '0;
  logic [1:0]  rcnt = '0;

  function automatic logic [17:0] fill(input int a);
    return 18'((a * 37 + 5) ^ (a << 9));
  endfunction

  function automatic logic [AW-1:0] form(input logic [AW-1:0] b, input logic [1:0] k,
                                         input logic l);
    logic [1:0] lo;
    lo = l ? b[1:0] + k : b[1:0] ^ k;
    return {b[AW-1:2], lo};
  endfunction

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic ok, wreq, w;
    int op;
    logic [AW-1:0] tgt;
    ok   = !ce_n && !ce2_n && ce3;
    wreq = !gw_n || (!bwe_n && lane_n != 2'b11);
    w    = 1'b0;
    op   = 0;
    if (!rst_n) begin
      ract = 0; rwr = 0; rbase = '0; rcnt = '0;
      return;
    end
    if (sleep) op = 0;
    else if (!adsp_n && !ce_n) op = ok ? 1 : 0;
    else if (!adsc_n) begin op = ok ? 1 : 0; w = ok && wreq; end
    else if (ract) begin op = adv_n ? 3 : 2; w = wreq; end
    case (op)
      1: tgt = addr;
      2: tgt = form(rbase, rcnt + 2'd1, lin);
      default: tgt = form(rbase, rcnt, lin);
    endcase
    if (w) begin
      for (int l = 0; l < 2; l++)
        if (!gw_n || !lane_n[l]) rmem[tgt][l*9 +: 9] = din[l*9 +: 9];
    end
    ract = (op != 0);
    rwr  = w;
    if (op == 1) begin rbase = addr; rcnt = '0; end
    if (op == 2) rcnt = rcnt + 2'd1;
  endtask

  task automatic check_out(input string tag);
    logic eoe;
    logic [17:0] ed;
    eoe = ract && !rwr && !oe_n && !sleep;
    ed  = eoe ? rmem[form(rbase, rcnt, lin)] : 18'd0;
    chk(tag, {17'd0, doe}, {17'd0, eoe});
    chk(tag, dout, ed);
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    #2;
    check_out(tag);
  endtask

  task automatic idle();
    ce_n = 0; ce2_n = 0; ce3 = 1; adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; lane_n = 2'b11; sleep = 0; oe_n = 0;
  endtask

  initial begin
    #(10 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(); addr = '0; din = '0; lin = 1;
    // R1: outputs off during and after reset
    tick("R1"); tick("R1");
    chk("R1", {17'd0, doe}, 18'd0);
    rst_n = 1;
    tick("R1");
    chk("R1", {17'd0, doe}, 18'd0);

    // R4: fill every word with ADSC global writes
    for (int a = 0; a < DEPTH; a++) begin
      adsc_n = 0; gw_n = 0; addr = AW'(a); din = fill(a);
      tick("R4");
    end
    idle();
    tick("R4");

    // R3: ADSP with global write low only reads
    adsp_n = 0; gw_n = 0; addr = 8'h12; din = 18'h3FFFF;
    tick("R3");
    chk("R3", dout, fill(8'h12));
    idle();
    adsc_n = 0; addr = 8'h12;
    tick("R3");
    chk("R3", dout, fill(8'h12));

    // R5 R7: linear burst from low bits 1
    idle(); lin = 1; adsp_n = 0; addr = 8'h31;
    tick("R7");
    idle(); adv_n = 0;
    tick("R5"); chk("R7", dout, fill(8'h32));
    tick("R5"); chk("R7", dout, fill(8'h33));
    tick("R5"); chk("R7", dout, fill(8'h30));
    tick("R5"); chk("R5", dout, fill(8'h31));
    // interleaved burst
    idle(); lin = 0; adsp_n = 0; addr = 8'h31;
    tick("R7");
    idle(); adv_n = 0;
    tick("R7"); chk("R7", dout, fill(8'h30));
    tick("R7"); chk("R7", dout, fill(8'h33));
    tick("R7"); chk("R7", dout, fill(8'h32));
    // R6: wait cycles hold the address
    idle();
    tick("R6"); chk("R6", dout, fill(8'h32));
    tick("R6"); chk("R6", dout, fill(8'h32));
    lin = 1;

    // R2: deselect by each enable, then strobe-free cycles stay off
    idle(); adsc_n = 0; ce2_n = 1; addr = 8'h44;
    tick("R2"); chk("R2", {17'd0, doe}, 18'd0);
    idle(); adv_n = 0;
    tick("R2"); chk("R2", {17'd0, doe}, 18'd0);
    idle(); adsp_n = 0; ce3 = 0; addr = 8'h44;
    tick("R2"); chk("R2", {17'd0, doe}, 18'd0);
    idle(); adsc_n = 0; ce_n = 1; adsp_n = 0; addr = 8'h44;
    tick("R2"); chk("R2", {17'd0, doe}, 18'd0);

    // R9: ADSP read then write on the following wait cycle
    idle(); adsp_n = 0; addr = 8'h40;
    tick("R9"); chk("R9", dout, fill(8'h40));
    idle(); gw_n = 0; din = 18'h2A5A5;
    tick("R9"); chk("R9", {17'd0, doe}, 18'd0);
    idle(); adsc_n = 0; addr = 8'h40;
    tick("R9"); chk("R9", dout, 18'h2A5A5);

    // R8: lane writes
    idle(); adsc_n = 0; bwe_n = 0; lane_n = 2'b10; addr = 8'h50; din = 18'h3FFFF;
    tick("R8");
    idle(); adsc_n = 0; addr = 8'h50;
    tick("R8"); chk("R8", dout, {fill(8'h50) & 18'h3FE00} | 18'h001FF);
    idle(); adsc_n = 0; bwe_n = 0; lane_n = 2'b01; addr = 8'h51; din = 18'h00000;
    tick("R8");
    idle(); adsc_n = 0; addr = 8'h51;
    tick("R8"); chk("R8", dout, fill(8'h51) & 18'h001FF);
    idle(); adsc_n = 0; lane_n = 2'b00; addr = 8'h52; din = 18'h0;
    tick("R8");
    idle(); adsc_n = 0; addr = 8'h52;
    tick("R8"); chk("R8", dout, fill(8'h52));

    // R11: sleep blocks a write and blanks output
    idle(); adsc_n = 0; gw_n = 0; sleep = 1; addr = 8'h60; din = 18'h0;
    tick("R11"); chk("R11", {17'd0, doe}, 18'd0);
    idle(); adsc_n = 0; addr = 8'h60;
    tick("R11"); chk("R11", dout, fill(8'h60));
    idle(); sleep = 1; #1;
    chk("R11", {17'd0, doe}, 18'd0);
    tick("R11");
    idle();
    tick("R11"); chk("R11", {17'd0, doe}, 18'd0);

    // R10: output enable high blanks a read
    idle(); adsc_n = 0; addr = 8'h70;
    tick("R10");
    idle(); oe_n = 1; #1;
    chk("R10", dout, 18'd0);
    oe_n = 0; #1;
    chk("R10", dout, fill(8'h70));

    // R12: random mix against the reference
    begin
      int unsigned seed = 32'h5eed1234;
      void'($urandom(seed));
    end
    for (int i = 0; i < 4000; i++) begin
      adsp_n = ($urandom % 8) != 0;
      adsc_n = ($urandom % 6) != 0;
      ce_n   = ($urandom % 10) == 0;
      ce2_n  = ($urandom % 12) == 0;
      ce3    = ($urandom % 12) != 0;
      adv_n  = $urandom % 2;
      gw_n   = ($urandom % 5) != 0;
      bwe_n  = $urandom % 2;
      lane_n = 2'($urandom);
      oe_n   = ($urandom % 6) == 0;
      sleep  = ($urandom % 40) == 0;
      if ($urandom % 16 == 0) lin = ~lin;
      addr   = AW'($urandom);
      din    = 18'($urandom);
      tick("R12");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) rmem[a] = 18'd0;
  end
endmodule